// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block decides, frame by frame, whether an incoming Ethernet frame is kept in the receive buffer. It watches the received byte stream, captures the first six bytes as the destination address, and runs a destination-address check. The address check may pass on any of several enabled classes: everything, the all-ones address, an exact match with the station's own programmed address, or a hit in a 64-entry hash table. Group addresses and individual addresses have separate hash enables.

The address result is then combined with a frame-quality check at the end of the frame. Each quality class has its own enable: a good frame, a frame with a failed CRC, a frame that is too short, and a frame that is too long. A frame is kept only when both stages agree. While the frame streams in, a write enable tells the buffer which bytes to store, and it stops after the length limit so that an overlong frame is cut short. The CRC check itself and the buffer memory lie outside the block.

Top module: `rxf_accept_filter`

## Requirements
- R1: After reset, `da_vld`, `da_pass`, `dec_vld` and `accept` are 0.
- R2: The first received byte of a frame is address bits 47:40, and the sixth is bits 7:0. `da_vld` is high for exactly one cycle, and that cycle is the one after the sixth byte is taken in. `da_pass` carries the address result from that cycle on.
- R3: With `da_en[0]` set, every frame passes the address check.
- R4: With `da_en[1]` set, an address of all ones passes. An all-ones address is never passed by `da_en[2]`, `da_en[3]` or `da_en[4]`, even when its hash bit is set.
- R5: With `da_en[2]` set, a non-broadcast address passes when it equals `my_addr` in all 48 bits.
- R6: The hash index is bits 31:26 of a CRC-32 register. The register uses the reflected polynomial 0xEDB88320 and starts at all ones. It takes the six address bytes in, each least significant bit first, and no final inversion is applied. The index selects one bit of `hash_tbl`. With `da_en[3]` set, a non-broadcast group address (bit 40, the first byte's bit 0, equal to 1) passes when that bit is set. With `da_en[4]` set, an individual address (bit 40 equal to 0) passes on the same condition.
- R7: `dec_vld` is high for one cycle, and that cycle is the one after `frame_end`. `accept` is high in that cycle only when the address check passed and at least one enabled quality class holds. The classes are: `qual_en[0]`, CRC good with length 64 to 1518; `qual_en[1]`, CRC bad; `qual_en[2]`, length below 64; `qual_en[3]`, length above 1518.
- R8: The length boundaries are exact. 63 bytes is short and 64 is not; 1518 bytes is not long and 1519 is.
- R9: A frame of fewer than six bytes is never accepted.
- R10: `wr_en` follows `byte_vld` for the first 1518 bytes of a frame and is 0 for every later byte.
- R11: `da_pass` keeps its value after the decision, until the first byte of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A received byte is present on `byte_dat` |
| byte_dat | input | 8 | Received byte |
| frame_end | input | 1 | End of the current frame; must be a cycle without a byte |
| crc_ok | input | 1 | CRC check result, valid with `frame_end` |
| my_addr | input | 48 | Station individual address, first byte in bits 47:40 |
| hash_tbl | input | 64 | Hash filter table |
| da_en | input | 5 | Address class enables: 0 all, 1 broadcast, 2 exact, 3 group hash, 4 individual hash |
| qual_en | input | 4 | Quality class enables: 0 good, 1 bad CRC, 2 short, 3 long |
| da_vld | output | 1 | Pulse: address result just became valid |
| da_pass | output | 1 | Address check result of the current or last frame |
| dec_vld | output | 1 | Pulse: frame decision valid |
| accept | output | 1 | Frame kept, valid with `dec_vld` |
| wr_en | output | 1 | Store the current byte in the buffer |

## Verification
The checker assumes three things about the inputs. `frame_end` never shares a cycle with `byte_vld`. The enables are steady while a frame is in flight. Each frame starts with its first byte directly after the previous frame's end. The bench keeps within these assumptions: it drives each frame as one contiguous byte run followed by a separate end cycle, and it changes the enables and the hash table only between frames. The sweeps cover all 32 address-enable combinations against six address kinds, including an all-ones address whose hash bit is deliberately set. They also cover all 16 quality-enable combinations against lengths on both sides of each boundary, with both CRC outcomes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam int          DA_BYTES = 6;

    // address class enable positions
    localparam int DAE_ALL    = 0;
    localparam int DAE_BCAST  = 1;
    localparam int DAE_EXACT  = 2;
    localparam int DAE_GHASH  = 3;
    localparam int DAE_IHASH  = 4;
    localparam int DAE_W      = 5;

    // quality class enable positions
    localparam int QE_GOOD    = 0;
    localparam int QE_BADCRC  = 1;
    localparam int QE_SHORT   = 2;
    localparam int QE_LONG    = 3;
    localparam int QE_W       = 4;
endpackage

// File: rtl/rxf_crc_step.sv
// One byte of reflected CRC-32, least significant data bit first.
module rxf_crc_step
    import rxf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [31:0]   crc_in,
    input  logic [DW-1:0] data,
    output logic [31:0]   crc_out
);
    logic [31:0] stage [DW+1];

    assign stage[0] = crc_in;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic fb;
        assign fb = stage[b][0] ^ data[b];
        assign stage[b+1] = (stage[b] >> 1) ^ (fb ? CRC_POLY : 32'h0);
    end

    assign crc_out = stage[DW];
endmodule

// File: rtl/rxf_da_class.sv
// Destination-address class filter (combinational).
module rxf_da_class
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 6,
    parameter int DA_W      = 48
) (
    input  logic [DA_W-1:0]            da,
    input  logic [DA_W-1:0]            my_addr,
    input  logic [(1<<HASH_BITS)-1:0]  hash_tbl,
    input  logic [HASH_BITS-1:0]       hash_idx,
    input  logic [DAE_W-1:0]           da_en,
    output logic                       pass
);
    logic is_bcast, is_group, own_hit, hash_hit, non_bc_pass;

    assign is_bcast = &da;
    assign is_group = da[DA_W-8];          // bit 0 of the first byte
    assign own_hit  = (da == my_addr);
    assign hash_hit = hash_tbl[hash_idx];

    always_comb begin
        non_bc_pass = (da_en[DAE_EXACT] & own_hit)
                    | (da_en[DAE_GHASH] &  is_group & hash_hit)
                    | (da_en[DAE_IHASH] & ~is_group & hash_hit);
        pass = da_en[DAE_ALL]
             | (is_bcast & da_en[DAE_BCAST])
             | (~is_bcast & non_bc_pass);
    end
endmodule

// File: rtl/rxf_quality.sv
// Frame-quality classes; length counter saturates above MAX_LEN.
module rxf_quality
    import rxf_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int LEN_W   = 11
) (
    input  logic [LEN_W-1:0] len,
    input  logic             crc_ok,
    input  logic [QE_W-1:0]  qual_en,
    output logic             meets
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

    logic [QE_W-1:0] cls;

    always_comb begin
        cls[QE_SHORT]  = (len < MIN_L);
        cls[QE_LONG]   = (len > MAX_L);
        cls[QE_BADCRC] = ~crc_ok;
        cls[QE_GOOD]   = crc_ok & ~cls[QE_SHORT] & ~cls[QE_LONG];
        meets          = |(cls & qual_en);
    end
endmodule

// File: rtl/rxf_accept_filter.sv
module rxf_accept_filter
    import rxf_pkg::*;
#(
    parameter int MIN_LEN   = 64,
    parameter int MAX_LEN   = 1518,
    parameter int HASH_BITS = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_vld,
    input  logic [7:0]                 byte_dat,
    input  logic                       frame_end,
    input  logic                       crc_ok,
    input  logic [47:0]                my_addr,
    input  logic [(1<<HASH_BITS)-1:0]  hash_tbl,
    input  logic [4:0]                 da_en,
    input  logic [3:0]                 qual_en,
    output logic                       da_vld,
    output logic                       da_pass,
    output logic                       dec_vld,
    output logic                       accept,
    output logic                       wr_en
);
    localparam int DA_W  = DA_BYTES * 8;
    localparam int LEN_W = $clog2(MAX_LEN + 2);
    localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] DA_LAST = LEN_W'(DA_BYTES - 1);
    localparam logic [LEN_W-1:0] DA_NUM  = LEN_W'(DA_BYTES);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [DA_W-1:0]  da;
        logic [31:0]      crc;
        logic             da_vld;
        logic             da_pass;
        logic             dec_vld;
        logic             accept;
    } st_t;

    st_t r_q, r_d;

    logic [31:0]     crc_src, crc_nx;
    logic [DA_W-1:0] da_nx;
    logic            da_hit, q_meets;

    assign crc_src = (r_q.cnt == '0) ? CRC_SEED : r_q.crc;
    assign da_nx   = {r_q.da[DA_W-9:0], byte_dat};

    rxf_crc_step #(.DW(8)) u_crc (
        .crc_in  (crc_src),
        .data    (byte_dat),
        .crc_out (crc_nx)
    );

    rxf_da_class #(.HASH_BITS(HASH_BITS), .DA_W(DA_W)) u_da (
        .da       (da_nx),
        .my_addr  (my_addr),
        .hash_tbl (hash_tbl),
        .hash_idx (crc_nx[31 -: HASH_BITS]),
        .da_en    (da_en),
        .pass     (da_hit)
    );

    rxf_quality #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_q (
        .len     (r_q.cnt),
        .crc_ok  (crc_ok),
        .qual_en (qual_en),
        .meets   (q_meets)
    );

    always_comb begin
        r_d         = r_q;
        r_d.da_vld  = 1'b0;
        r_d.dec_vld = 1'b0;
        r_d.accept  = 1'b0;

        if (byte_vld) begin
            if (r_q.cnt == '0) begin
                r_d.da_pass = 1'b0;
            end
            if (r_q.cnt < DA_NUM) begin
                r_d.da  = da_nx;
                r_d.crc = crc_nx;
            end
            if (r_q.cnt == DA_LAST) begin
                r_d.da_vld  = 1'b1;
                r_d.da_pass = da_hit;
            end
            if (r_q.cnt <= MAX_L) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end

        if (frame_end) begin
            r_d.dec_vld = 1'b1;
            r_d.accept  = r_q.da_pass & (r_q.cnt >= DA_NUM) & q_meets;
            r_d.cnt     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign da_vld  = r_q.da_vld;
    assign da_pass = r_q.da_pass;
    assign dec_vld = r_q.dec_vld;
    assign accept  = r_q.accept;
    assign wr_en   = byte_vld & (r_q.cnt < MAX_L);
endmodule

// File: rtl/rxf_accept_chk.sv
module rxf_accept_chk #(
    parameter int MAX_LEN = 1518
) (
    input logic clk,
    input logic rst_n,
    input logic byte_vld,
    input logic frame_end,
    input logic all_en,
    input logic da_vld,
    input logic da_pass,
    input logic dec_vld,
    input logic accept,
    input logic wr_en
);
    localparam int CW = $clog2(MAX_LEN + 2) + 1;

    logic [CW-1:0] wr_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            wr_cnt_q <= '0;
        end else if (wr_en) begin
            wr_cnt_q <= wr_cnt_q + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !da_vld && !dec_vld && !accept);

    // R2
    da_vld_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        da_vld |-> $past(byte_vld));

    // R3
    all_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        da_vld && $past(all_en) |-> da_pass);

    // R7
    dec_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(frame_end));

    // R7
    accept_needs_da_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> dec_vld && da_pass);

    // R10
    wr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> byte_vld);

    // R10
    wr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_q <= CW'(MAX_LEN));
endmodule

bind rxf_accept_filter rxf_accept_chk #(.MAX_LEN(MAX_LEN)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .frame_end (frame_end),
    .all_en    (da_en[0]),
    .da_vld    (da_vld),
    .da_pass   (da_pass),
    .dec_vld   (dec_vld),
    .accept    (accept),
    .wr_en     (wr_en)
);

// File: tb/test_rxf_accept_filter.sv
`timescale 1ns/1ps
module test_rxf_accept_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = 8'h0;
    logic        frame_end = 1'b0;
    logic        crc_ok = 1'b0;
    logic [47:0] my_addr = 48'h02_11_22_33_44_55;
    logic [63:0] hash_tbl = 64'h0;
    logic [4:0]  da_en = 5'h0;
    logic [3:0]  qual_en = 4'h0;
    logic        da_vld, da_pass, dec_vld, accept, wr_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rxf_accept_filter i_rxf_accept_filter (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .frame_end(frame_end), .crc_ok(crc_ok), .my_addr(my_addr),
        .hash_tbl(hash_tbl), .da_en(da_en), .qual_en(qual_en),
        .da_vld(da_vld), .da_pass(da_pass), .dec_vld(dec_vld),
        .accept(accept), .wr_en(wr_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [5:0] hidx(input logic [47:0] da);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = da[47-8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                logic f = c[0] ^ b[k];
                c = c >> 1;
                if (f) c = c ^ 32'hEDB8_8320;
            end
        end
        return c[31:26];
    endfunction

    function automatic bit exp_da(input logic [47:0] da, input logic [4:0] en,
                                  input logic [63:0] tbl, input logic [47:0] me);
        bit bc  = (da == 48'hFFFF_FFFF_FFFF);
        bit grp = da[40];
        bit hit = tbl[hidx(da)];
        if (en[0]) return 1;
        if (bc) return en[1];
        return (en[2] && da == me) || (en[3] && grp && hit) || (en[4] && !grp && hit);
    endfunction

    function automatic bit exp_q(input int len, input bit ok, input logic [3:0] q);
        bit good = ok && len >= 64 && len <= 1518;
        return (q[0] && good) || (q[1] && !ok) || (q[2] && len < 64) || (q[3] && len > 1518);
    endfunction

    // Drive one frame; check R2, R7, R9, R10, R11 and the address result.
    task automatic run_frame(input logic [47:0] da, input int len, input bit ok,
                             input bit e_pass, input bit e_acc, input string da_req);
        int vld_cnt = 0;
        int vld_pos = -1;
        int wr_cnt = 0;
        int pass_seen = 0;
        for (int k = 0; k <= len + 1; k++) begin
            @(negedge clk);
            if (da_vld) begin vld_cnt++; vld_pos = k; end
            if (k == 6) pass_seen = da_pass;
            if (k == len + 1) begin
                chk("R7 dec_vld", dec_vld, 1);
                chk((len < 6) ? "R9 short accept" : "R7/R8 accept", accept, e_acc);
            end
            byte_vld  = 1'b0;
            frame_end = 1'b0;
            if (k < len) begin
                byte_vld = 1'b1;
                byte_dat = (k < 6) ? da[47-8*k -: 8] : 8'(k * 7);
            end else if (k == len) begin
                frame_end = 1'b1;
                crc_ok    = ok;
            end
            #1;
            if (wr_en) wr_cnt++;
        end
        chk("R2 da_vld count", vld_cnt, (len >= 6) ? 1 : 0);
        if (len >= 6) begin
            chk("R2 da_vld cycle", vld_pos, 6);
            chk(da_req, pass_seen, e_pass);
        end
        chk("R10 wr count", wr_cnt, (len > 1518) ? 1518 : len);
        @(negedge clk);
        chk("R7 dec_vld single", dec_vld, 0);
        chk("R11 da_pass hold", da_pass, (len >= 6) ? e_pass : 0);
    endtask

    logic [47:0] das [6];

    initial begin
        das[0] = 48'hFFFF_FFFF_FFFF;
        das[1] = 48'h02_11_22_33_44_55;
        das[2] = 48'h01_00_5E_00_00_01;
        das[3] = 48'h01_00_5E_7F_12_34;
        das[4] = 48'h00_AA_BB_CC_DD_EE;
        das[5] = 48'h00_12_34_56_78_9A;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 da_vld", da_vld, 0);
        chk("R1 da_pass", da_pass, 0);
        chk("R1 dec_vld", dec_vld, 0);
        chk("R1 accept", accept, 0);

        // hash bits for the two hit addresses and for broadcast (R4 check)
        hash_tbl = 64'h0;
        hash_tbl[hidx(das[2])] = 1'b1;
        hash_tbl[hidx(das[4])] = 1'b1;
        hash_tbl[hidx(das[0])] = 1'b1;

        // address sweep: R3 R4 R5 R6 with a good 64-byte frame
        qual_en = 4'b0001;
        for (int e = 0; e < 32; e++) begin
            for (int d = 0; d < 6; d++) begin
                bit p;
                da_en = 5'(e);
                p = exp_da(das[d], da_en, hash_tbl, my_addr);
                run_frame(das[d], 64, 1'b1, p, p,
                          (d == 0) ? "R4 bcast" : (d == 1) ? "R5 exact" :
                          (e[0]) ? "R3 all" : "R6 hash");
            end
        end

        // quality sweep: R7 R8 R9 R10 with every address passing
        da_en = 5'b00001;
        for (int q = 0; q < 16; q++) begin
            for (int c = 0; c < 2; c++) begin
                int lens [5] = '{5, 63, 64, 1518, 1519};
                for (int l = 0; l < 5; l++) begin
                    bit a;
                    qual_en = 4'(q);
                    a = (lens[l] >= 6) && exp_q(lens[l], c[0], qual_en);
                    run_frame(das[5], lens[l], c[0], 1'b1, a, "R3 all");
                end
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule